// File: doc/BRIEF.md
# Converter sample holding and software-trigger register block

This block is the register front end of a two-channel digital-to-analog converter. Software stores a 12-bit sample code for each channel through a simple single-cycle bus. Each channel's holding register can be reached through two address views. The right-aligned view carries the code in the low bits of the word. The left-aligned view carries the code four bits higher.

A trigger register holds one request bit per channel. Writing a 1 to a channel's bit copies that channel's held code into its output register. The output register drives the converter code pins. The hardware clears the request bit on the clock after the copy. A parameter removes the second channel, and its request bit, data views and output then read as zero.

Reads are combinational from `addr_i`. A write is taken on the rising clock edge when `req_i` and `we_i` are both high.

Top module: `dac_hold_trig`

## Requirements
- R1: After reset, every mapped address reads 0 and both converter code outputs are 0.
- R2: Writing offset 0x08 stores wdata bits 11:0 as the channel-1 code. Reading 0x08 returns the code in bits 11:0, with bits 31:12 reading 0.
- R3: Writing offset 0x0C stores wdata bits 15:4 as the channel-1 code. Reading 0x0C returns the code in bits 15:4, with bits 3:0 and 31:16 reading 0.
- R4: Both views of a channel alias one register. A write through either view is visible on a read through the other, shifted to that view's field.
- R5: Channel 2 uses 0x14 (right view) and 0x18 (left view), with the same field layouts. Its code is independent of channel 1.
- R6: A code output changes only through a trigger-driven load. A write to a holding register leaves the output unchanged.
- R7: Writing 1 to trigger bit n at offset 0x04 (bit 0 for channel 1, bit 1 for channel 2) makes that bit read 1 after the write edge. At the next edge the channel's output takes the held code.
- R8: The trigger bit reads 0 one clock after the load. Writing 0 to a trigger bit has no effect.
- R9: A trigger write that lands on the edge where the bit would clear keeps the bit set. It causes a second load on the following edge.
- R10: With DUAL_CH = 0, trigger bit 1 reads 0 and ignores writes. The channel-2 data views read 0, and the channel-2 output stays 0.
- R11: Trigger register bits 31:2 and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| dac1_code_o | output | 12 | Channel-1 converter code |
| dac2_code_o | output | 12 | Channel-2 converter code |

## Verification
The bench writes through one view and reads through the other. A design that kept separate registers per view, or shifted the left view by the wrong amount, returns stale or misplaced codes. It times the trigger edge by edge. A design that cleared the bit with the load, or loaded on the write edge itself, shows the wrong bit value or the wrong output at the sampled half-cycle. A retrigger placed on the clear edge catches a design that lets the clear win and skips the second load. A single-channel instance shows whether bit 1 or the channel-2 views leak through.

// File: rtl/dac_hold_pkg.sv
package dac_hold_pkg;
  localparam int unsigned CODE_W   = 12;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned LEFT_SH  = 4;
  localparam int unsigned MAX_CH   = 2;
  localparam int unsigned TRIG_OFF = 'h04;
  localparam int unsigned VIEW_BASE = 'h08;
  localparam int unsigned CH_STRIDE = 'h0C;

  function automatic int unsigned right_off(int unsigned ch);
    return VIEW_BASE + ch * CH_STRIDE;
  endfunction

  function automatic int unsigned left_off(int unsigned ch);
    return VIEW_BASE + 4 + ch * CH_STRIDE;
  endfunction
endpackage

// File: rtl/dac_chan.sv
module dac_chan
  import dac_hold_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_we_i,
  input  logic [CODE_W-1:0] hold_d_i,
  input  logic              trig_set_i,
  output logic [CODE_W-1:0] hold_o,
  output logic [CODE_W-1:0] code_o,
  output logic              trig_o
);
  logic [CODE_W-1:0] hold_q, out_q;
  logic              trig_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (hold_we_i) hold_q <= hold_d_i;
      if (trig_q && !done_q) begin
        out_q  <= hold_q;
        done_q <= 1'b1;
      end
      if (done_q) begin
        // new request on the clear edge wins
        trig_q <= trig_set_i;
        done_q <= 1'b0;
      end else if (trig_set_i) begin
        trig_q <= 1'b1;
      end
    end
  end

  assign hold_o = hold_q;
  assign code_o = out_q;
  assign trig_o = trig_q;

  // R6
  out_only_on_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_q |=> $stable(out_q));
  // R7
  trig_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_set_i && !trig_q) |=> trig_q);
  // R7
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && !done_q) |=> (out_q == $past(hold_q)));
  // R8
  self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && done_q && !trig_set_i) |=> !trig_q);
  // R9
  retrig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && trig_set_i) |=> (trig_q && !done_q));
endmodule

// File: rtl/dac_rd_mux.sv
module dac_rd_mux
  import dac_hold_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [MAX_CH-1:0][CODE_W-1:0]  hold_i,
  input  logic [MAX_CH-1:0]              trig_i,
  output logic [BUS_W-1:0]               rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(TRIG_OFF)) rdata_o[MAX_CH-1:0] = trig_i;
    for (int unsigned c = 0; c < MAX_CH; c++) begin
      if (addr_i == ADDR_W'(right_off(c))) rdata_o[CODE_W-1:0] = hold_i[c];
      if (addr_i == ADDR_W'(left_off(c)))  rdata_o[CODE_W+LEFT_SH-1:LEFT_SH] = hold_i[c];
    end
  end
endmodule

// File: rtl/dac_hold_trig.sv
module dac_hold_trig
  import dac_hold_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter bit          DUAL_CH = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [CODE_W-1:0] dac1_code_o,
  output logic [CODE_W-1:0] dac2_code_o
);
  logic                              wr;
  logic [MAX_CH-1:0][CODE_W-1:0]     hold_w, code_w;
  logic [MAX_CH-1:0]                 trig_w;

  assign wr = req_i && we_i;

  for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
    if (c == 0 || DUAL_CH) begin : g_on
      logic              wr_r, wr_l;
      logic [CODE_W-1:0] d;
      assign wr_r = wr && (addr_i == ADDR_W'(right_off(c)));
      assign wr_l = wr && (addr_i == ADDR_W'(left_off(c)));
      assign d    = wr_l ? wdata_i[CODE_W+LEFT_SH-1:LEFT_SH] : wdata_i[CODE_W-1:0];

      dac_chan i_chan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hold_we_i (wr_r || wr_l),
        .hold_d_i  (d),
        .trig_set_i(wr && (addr_i == ADDR_W'(TRIG_OFF)) && wdata_i[c]),
        .hold_o    (hold_w[c]),
        .code_o    (code_w[c]),
        .trig_o    (trig_w[c])
      );
    end else begin : g_off
      assign hold_w[c] = '0;
      assign code_w[c] = '0;
      assign trig_w[c] = 1'b0;
    end
  end

  dac_rd_mux #(.ADDR_W(ADDR_W)) i_rd_mux (
    .addr_i (addr_i),
    .hold_i (hold_w),
    .trig_i (trig_w),
    .rdata_o(rdata_o)
  );

  assign dac1_code_o = code_w[0];
  assign dac2_code_o = code_w[1];
endmodule

// File: tb/test_dac_hold_trig.sv
`timescale 1ns/1ps
module test_dac_hold_trig;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s;
  logic [11:0] c1, c2, c1_s, c2_s;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dac_hold_trig #(.ADDR_W(8), .DUAL_CH(1'b1)) i_dac_hold_trig (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .dac1_code_o(c1), .dac2_code_o(c2));

  dac_hold_trig #(.ADDR_W(8), .DUAL_CH(1'b0)) i_dac_hold_trig_single (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_s), .dac1_code_o(c1_s), .dac2_code_o(c2_s));

  // {write, addr, data}; for reads data is the expected value
  localparam int NV = 11;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h08, 32'hFFFF_FABC},  // R2
    {1'b0, 8'h08, 32'h0000_0ABC},  // R2
    {1'b0, 8'h0C, 32'h0000_ABC0},  // R4
    {1'b1, 8'h0C, 32'hFFFF_1234},  // R3
    {1'b0, 8'h0C, 32'h0000_1230},  // R3
    {1'b0, 8'h08, 32'h0000_0123},  // R4
    {1'b1, 8'h14, 32'h0000_0FED},  // R5
    {1'b0, 8'h18, 32'h0000_FED0},  // R5
    {1'b0, 8'h08, 32'h0000_0123},  // R5
    {1'b0, 8'h04, 32'h0000_0000},  // R11
    {1'b0, 8'h20, 32'h0000_0000}   // R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // combinational read, consumes no edge
  task automatic rd(input logic [7:0] a, output logic [31:0] m, output logic [31:0] s);
    req = 1'b1; we = 1'b0; addr = a;
    #0.5;
    m = rdata; s = rdata_s;
    req = 1'b0;
  endtask

  initial begin
    logic [31:0] m, s;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (VEC[i]) begin
      rd(VEC[i][39:32], m, s);
      check("R1 reset read", m, 32'h0);
    end
    check("R1 dac1 reset", {20'h0, c1}, 32'h0);
    check("R1 dac2 reset", {20'h0, c2}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][39:32], m, s);
        check($sformatf("R2-table step %0d", i), m, VEC[i][31:0]);
      end
    end

    // R6 holding writes left outputs alone
    check("R6 dac1 untouched", {20'h0, c1}, 32'h0);
    check("R6 dac2 untouched", {20'h0, c2}, 32'h0);

    // R7 trigger channel 1
    wr(8'h04, 32'h0000_0001);
    rd(8'h04, m, s);
    check("R7 trig bit set", m, 32'h1);
    check("R7 no load on write edge", {20'h0, c1}, 32'h0);
    @(negedge clk);
    check("R7 dac1 loaded", {20'h0, c1}, 32'h123);
    check("R7 dac2 unaffected", {20'h0, c2}, 32'h0);
    rd(8'h04, m, s);
    check("R8 bit still set on load", m, 32'h1);
    @(negedge clk);
    rd(8'h04, m, s);
    check("R8 bit cleared", m, 32'h0);

    // R8 writing 0 has no effect
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, m, s);
    check("R8 write zero", m, 32'h0);
    @(negedge clk);
    check("R8 dac1 unchanged", {20'h0, c1}, 32'h123);
    check("R8 dac2 unchanged", {20'h0, c2}, 32'h0);

    // R9 retrigger on the clear edge, channel 2
    wr(8'h04, 32'h0000_0002);
    wr(8'h14, 32'h0000_00AA);          // load edge: old code FED goes out
    check("R9 first load", {20'h0, c2}, 32'hFED);
    wr(8'h04, 32'h0000_0002);          // clear edge
    rd(8'h04, m, s);
    check("R9 bit kept", m, 32'h2);
    check("R9 dac2 before reload", {20'h0, c2}, 32'hFED);
    @(negedge clk);
    check("R9 second load", {20'h0, c2}, 32'h0AA);
    @(negedge clk);
    rd(8'h04, m, s);
    check("R9 bit clears after reload", m, 32'h0);

    // R10 single-channel instance
    wr(8'h04, 32'h0000_0003);
    rd(8'h04, m, s);
    check("R10 dual reads both bits", m, 32'h3);
    check("R10 single bit1 reads 0", s, 32'h1);
    rd(8'h14, m, s);
    check("R10 ch2 view reads 0", s, 32'h0);
    @(negedge clk);
    check("R10 single dac1 loaded", {20'h0, c1_s}, 32'h123);
    check("R10 single dac2 stays 0", {20'h0, c2_s}, 32'h0);
    repeat (2) @(negedge clk);
    rd(8'h04, m, s);
    check("R11 trig reads clear", m, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule